// File: doc/BRIEF.md
# Next Instruction Address Unit

This block owns the program counter of a 32-bit load/store core and works out, every cycle, which address the core fetches next. It looks at the fetched instruction word and the two register operands that were read for it. Only the control-flow opcodes are decoded. These are the two compare-and-branch forms, the two absolute jumps (one of them also links a return address) and the register-indirect jump. Every other encoding advances the PC by one instruction.

Three target forms feed one selector:
- A word-scaled, sign-extended displacement added to the already-incremented PC.
- A 26-bit word index placed under the current PC's top four bits.
- The full value of the first register operand.

A synchronous reset clears the PC. A stall input freezes it. During a stall the combinational next-address output still shows the pending target. For the linking jump the block presents the return address and a write strobe. The register file stores that address in register 31.

Top module: `flow_pc_unit`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge, loads the PC with 0. Reset takes priority over stall.
- R2: `seq_addr` always equals PC+4 modulo 2^32. Any encoding that is not a control-flow form gives `next_pc` = PC+4. This includes opcode 0 with a function code other than 8.
- R3: Opcode 4 (bits 31:26) is the branch-if-equal form. When `rs_val` equals `rt_val`, `next_pc` is PC+4 plus the 16-bit field (bits 15:0), sign-extended and multiplied by 4. Otherwise `next_pc` is PC+4.
- R4: Opcode 5 is the branch-if-different form. It uses the same target as R3, but it is taken only when `rs_val` differs from `rt_val`. Otherwise `next_pc` is PC+4.
- R5: A negative displacement moves the target backwards, and the sum wraps modulo 2^32.
- R6: Opcode 2 is the plain jump. `next_pc` is {PC[31:28], bits 25:0 of the word, 2'b00}, so the top four PC bits are kept.
- R7: Opcode 3 is the linking jump. It has the same target as R6. While it is presented and stall is low, `link_we` is 1 and `link_addr` equals PC+4. For any other word, `link_we` is 0 and `link_addr` is 0.
- R8: Opcode 0 with function code 8 (bits 5:0) sets `next_pc` to the full 32-bit `rs_val`.
- R9: While stall is high and reset is low, the PC keeps its value and `link_we` is 0. `next_pc` still shows the computed target.
- R10: When neither reset nor stall is high, the PC takes the value `next_pc` had just before the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the PC when high |
| instr | input | 32 | Fetched instruction word at the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| seq_addr | output | 32 | PC+4 |
| next_pc | output | 32 | Address the PC takes at the next unstalled edge |
| link_addr | output | 32 | Return address for the linking jump, else 0 |
| link_we | output | 1 | Strobe that writes `link_addr` into register 31 |

## Verification
Stall and a taken control transfer can land in the same cycle. When a taken branch or the linking jump arrives while the pipeline is frozen, the PC must hold, the link strobe must stay low, and `next_pc` must still show the target. The bench provokes this both on purpose and by raising stall at random during a mixed instruction stream. On every clock, the reference model's PC and expected outputs are compared with the ports. A second overlap is reset together with stall, where reset must win.

// File: rtl/flow_pc_pkg.sv
`timescale 1ns/1ps
package flow_pc_pkg;

   typedef enum logic [2:0] {
      FK_SEQ  = 3'd0,
      FK_BEQ  = 3'd1,
      FK_BNE  = 3'd2,
      FK_JMP  = 3'd3,
      FK_JAL  = 3'd4,
      FK_JREG = 3'd5
   } flow_kind_t;

   localparam int OPC_W = 6;
   localparam int FN_W  = 6;

   localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
   localparam logic [OPC_W-1:0] OPC_JMP     = 6'd2;
   localparam logic [OPC_W-1:0] OPC_JAL     = 6'd3;
   localparam logic [OPC_W-1:0] OPC_BEQ     = 6'd4;
   localparam logic [OPC_W-1:0] OPC_BNE     = 6'd5;
   localparam logic [FN_W-1:0]  FN_JREG     = 6'd8;

endpackage

// File: rtl/flow_decode.sv
`timescale 1ns/1ps
module flow_decode
   import flow_pc_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic [FN_W-1:0]  funct,
   output flow_kind_t       kind
);

   always_comb begin
      unique case (opcode)
         OPC_BEQ:     kind = FK_BEQ;
         OPC_BNE:     kind = FK_BNE;
         OPC_JMP:     kind = FK_JMP;
         OPC_JAL:     kind = FK_JAL;
         OPC_SPECIAL: kind = (funct == FN_JREG) ? FK_JREG : FK_SEQ;
         default:     kind = FK_SEQ;
      endcase
   end

endmodule

// File: rtl/flow_target.sv
`timescale 1ns/1ps
module flow_target #(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16,
   parameter int IDX_W  = 26,
   parameter int SHIFT  = 2
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] pc_inc,
   input  logic [IMM_W-1:0]  imm,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] br_tgt,
   output logic [ADDR_W-1:0] jmp_tgt
);

   localparam int EXT_W  = ADDR_W - IMM_W - SHIFT;
   localparam int KEEP_W = ADDR_W - IDX_W - SHIFT;

   logic [ADDR_W-1:0] disp;

   generate
      if (SHIFT == 0) begin : g_noscale
         assign disp    = {{EXT_W{imm[IMM_W-1]}}, imm};
         assign jmp_tgt = {pc[ADDR_W-1 -: KEEP_W], idx};
      end else begin : g_scale
         assign disp    = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
         assign jmp_tgt = {pc[ADDR_W-1 -: KEEP_W], idx, {SHIFT{1'b0}}};
      end
   endgenerate

   assign br_tgt = pc_inc + disp;

endmodule

// File: rtl/flow_select.sv
`timescale 1ns/1ps
module flow_select
   import flow_pc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  flow_kind_t        kind,
   input  logic              ops_equal,
   input  logic [ADDR_W-1:0] pc_inc,
   input  logic [ADDR_W-1:0] br_tgt,
   input  logic [ADDR_W-1:0] jmp_tgt,
   input  logic [ADDR_W-1:0] reg_tgt,
   output logic [ADDR_W-1:0] next_pc
);

   always_comb begin
      next_pc = pc_inc;
      unique case (kind)
         FK_BEQ:  if (ops_equal)  next_pc = br_tgt;
         FK_BNE:  if (!ops_equal) next_pc = br_tgt;
         FK_JMP,
         FK_JAL:  next_pc = jmp_tgt;
         FK_JREG: next_pc = reg_tgt;
         default: next_pc = pc_inc;
      endcase
   end

endmodule

// File: rtl/flow_pc_reg.sv
`timescale 1ns/1ps
module flow_pc_reg #(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stall,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)        q <= RESET_ADDR;
      else if (!stall) q <= d;
   end

endmodule

// File: rtl/flow_pc_unit.sv
`timescale 1ns/1ps
module flow_pc_unit
   import flow_pc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int INSTR_W    = 32,
   parameter int INSN_BYTES = 4,
   parameter int IMM_W      = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               stall,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  rs_val,
   input  logic [ADDR_W-1:0]  rt_val,
   output logic [ADDR_W-1:0]  pc,
   output logic [ADDR_W-1:0]  seq_addr,
   output logic [ADDR_W-1:0]  next_pc,
   output logic [ADDR_W-1:0]  link_addr,
   output logic               link_we
);

   localparam int SHIFT   = $clog2(INSN_BYTES);
   localparam int IDX_W   = INSTR_W - OPC_W;
   localparam int OPC_LSB = INSTR_W - OPC_W;

   generate
      if (INSN_BYTES != (1 << SHIFT)) begin : g_bad_bytes
         $error("INSN_BYTES must be a power of two");
      end
      if (ADDR_W <= IDX_W + SHIFT) begin : g_bad_addr
         $error("ADDR_W too narrow to keep upper PC bits on jumps");
      end
      if (ADDR_W < IMM_W + SHIFT) begin : g_bad_imm
         $error("ADDR_W narrower than scaled displacement");
      end
      if (IMM_W + FN_W > IDX_W) begin : g_bad_fields
         $error("instruction fields overlap the opcode");
      end
   endgenerate

   flow_kind_t        kind;
   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] br_tgt;
   logic [ADDR_W-1:0] jmp_tgt;

   assign pc_inc = pc + ADDR_W'(INSN_BYTES);

   flow_decode i_decode (
      .opcode (instr[INSTR_W-1:OPC_LSB]),
      .funct  (instr[FN_W-1:0]),
      .kind   (kind)
   );

   flow_target #(
      .ADDR_W (ADDR_W),
      .IMM_W  (IMM_W),
      .IDX_W  (IDX_W),
      .SHIFT  (SHIFT)
   ) i_target (
      .pc      (pc),
      .pc_inc  (pc_inc),
      .imm     (instr[IMM_W-1:0]),
      .idx     (instr[IDX_W-1:0]),
      .br_tgt  (br_tgt),
      .jmp_tgt (jmp_tgt)
   );

   flow_select #(
      .ADDR_W (ADDR_W)
   ) i_select (
      .kind      (kind),
      .ops_equal (rs_val == rt_val),
      .pc_inc    (pc_inc),
      .br_tgt    (br_tgt),
      .jmp_tgt   (jmp_tgt),
      .reg_tgt   (rs_val),
      .next_pc   (next_pc)
   );

   flow_pc_reg #(
      .ADDR_W     (ADDR_W),
      .RESET_ADDR ('0)
   ) i_pc_reg (
      .clk   (clk),
      .rst   (rst),
      .stall (stall),
      .d     (next_pc),
      .q     (pc)
   );

   assign seq_addr  = pc_inc;
   assign link_we   = (kind == FK_JAL) && !stall;
   assign link_addr = (kind == FK_JAL) ? pc_inc : '0;

endmodule

// File: rtl/flow_pc_checker.sv
`timescale 1ns/1ps
module flow_pc_checker #(
   parameter int ADDR_W  = 32,
   parameter int INSTR_W = 32
) (
   input logic               clk,
   input logic               rst,
   input logic               stall,
   input logic [INSTR_W-1:0] instr,
   input logic [ADDR_W-1:0]  rs_val,
   input logic [ADDR_W-1:0]  pc,
   input logic [ADDR_W-1:0]  seq_addr,
   input logic [ADDR_W-1:0]  next_pc,
   input logic [ADDR_W-1:0]  link_addr,
   input logic               link_we
);

   logic [5:0] op;
   assign op = instr[INSTR_W-1 -: 6];

   AST_RESET_ZERO: assert property (@(posedge clk) rst |=> pc == '0); // R1

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      stall |=> pc == $past(pc)); // R9

   AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      !stall |=> pc == $past(next_pc)); // R10

   AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (rst)
      link_we |-> (op == 6'd3 && !stall)); // R7

   AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
      link_we |-> link_addr == seq_addr); // R7

   AST_JREG_TARGET: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd0 && instr[5:0] == 6'd8) |-> next_pc == rs_val); // R8

   AST_JUMP_TOP: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd2 || op == 6'd3) |-> next_pc[ADDR_W-1 -: 4] == pc[ADDR_W-1 -: 4]); // R6

endmodule

bind flow_pc_unit flow_pc_checker #(
   .ADDR_W  (ADDR_W),
   .INSTR_W (INSTR_W)
) i_flow_pc_checker (
   .clk       (clk),
   .rst       (rst),
   .stall     (stall),
   .instr     (instr),
   .rs_val    (rs_val),
   .pc        (pc),
   .seq_addr  (seq_addr),
   .next_pc   (next_pc),
   .link_addr (link_addr),
   .link_we   (link_we)
);

// File: tb/test_flow_pc_unit.sv
`timescale 1ns/1ps
module test_flow_pc_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall = 1'b0;
   logic [31:0] instr = 32'h0;
   logic [31:0] rs_val = 32'h0;
   logic [31:0] rt_val = 32'h0;
   logic [31:0] pc, seq_addr, next_pc, link_addr;
   logic        link_we;

   int          total = 0;
   int          bad = 0;
   bit          finished = 0;
   logic [31:0] m_pc = 32'h0;
   bit          m_valid = 0;

   always #4 clk = ~clk;

   flow_pc_unit i_flow_pc_unit (
      .clk (clk), .rst (rst), .stall (stall), .instr (instr),
      .rs_val (rs_val), .rt_val (rt_val), .pc (pc), .seq_addr (seq_addr),
      .next_pc (next_pc), .link_addr (link_addr), .link_we (link_we)
   );

   function automatic logic [31:0] ref_next(logic [31:0] p, logic [31:0] w,
                                            logic [31:0] a, logic [31:0] b);
      longint off;
      off = longint'($signed(w[15:0])) * 4;
      case (w[31:26])
         6'd4: return (a == b) ? 32'(longint'(p) + 4 + off) : p + 32'd4;
         6'd5: return (a != b) ? 32'(longint'(p) + 4 + off) : p + 32'd4;
         6'd2, 6'd3: return {p[31:28], w[25:0], 2'b00};
         6'd0: return (w[5:0] == 6'd8) ? a : p + 32'd4;
         default: return p + 32'd4;
      endcase
   endfunction

   function automatic string tag_of(logic [31:0] w);
      case (w[31:26])
         6'd4: return "R3";
         6'd5: return "R4";
         6'd2: return "R6";
         6'd3: return "R7";
         6'd0: return (w[5:0] == 6'd8) ? "R8" : "R2";
         default: return "R2";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input bit st, input bit r,
                       input string tag_in);
      logic [31:0] exp_n;
      string tag;
      tag = (tag_in == "") ? tag_of(w) : tag_in;
      @(negedge clk);
      if (m_valid) check(pc === m_pc, "R10", "pc", pc, m_pc);
      instr = w; rs_val = a; rt_val = b; stall = st; rst = r;
      #1;
      exp_n = ref_next(m_pc, w, a, b);
      if (m_valid && !r) begin
         check(next_pc === exp_n, tag, "next_pc", next_pc, exp_n);
         check(seq_addr === m_pc + 32'd4, "R2", "seq_addr", seq_addr, m_pc + 32'd4);
         check(link_we === (w[31:26] == 6'd3 && !st), st ? "R9" : "R7",
               "link_we", {31'd0, link_we}, {31'd0, (w[31:26] == 6'd3 && !st)});
         check(link_addr === ((w[31:26] == 6'd3) ? m_pc + 32'd4 : 32'd0), "R7",
               "link_addr", link_addr, (w[31:26] == 6'd3) ? m_pc + 32'd4 : 32'd0);
      end
      @(posedge clk);
      if (r) begin m_pc = 32'h0; m_valid = 1; end
      else if (!st) m_pc = exp_n;
   endtask

   function automatic logic [31:0] br(logic [5:0] op, logic [15:0] imm);
      return {op, 5'd1, 5'd2, imm};
   endfunction

   localparam logic [31:0] NOP  = 32'h0000_0020;
   localparam logic [31:0] JREG = 32'h0060_0008;

   initial begin
      #(8 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset wins over stall
      step(NOP, 0, 0, 1, 1, "R1");
      step(NOP, 0, 0, 1, 1, "R1");
      @(negedge clk);
      check(pc === 32'h0, "R1", "reset pc", pc, 32'h0);
      // R2 sequential and non-jump special function
      step(NOP, 5, 6, 0, 0, "R2");
      step(32'h2002_0010, 5, 6, 0, 0, "R2");
      step(32'h0000_0009, 32'h40, 0, 0, 0, "R2");
      // R3 equal branch taken and not taken
      step(br(6'd4, 16'd2), 7, 7, 0, 0, "R3");
      step(br(6'd4, 16'd5), 7, 8, 0, 0, "R3");
      // R4 different branch
      step(br(6'd5, 16'd3), 1, 2, 0, 0, "R4");
      step(br(6'd5, 16'd3), 9, 9, 0, 0, "R4");
      // R5 backward branch and wrap below zero
      step(br(6'd5, 16'hFFFC), 1, 2, 0, 0, "R5");
      step(JREG, 32'h0000_0004, 0, 0, 0, "R8");
      step(br(6'd4, 16'hFFFC), 3, 3, 0, 0, "R5");
      step(NOP, 0, 0, 0, 0, "R2");
      // R6 jump keeps top bits
      step(JREG, 32'hA000_0010, 0, 0, 0, "R8");
      step({6'd2, 26'h3FF_FFFF}, 0, 0, 0, 0, "R6");
      step({6'd2, 26'h000_0123}, 0, 0, 0, 0, "R6");
      // R7 linking jump
      step({6'd3, 26'h000_0400}, 0, 0, 0, 0, "R7");
      // R9 stall coinciding with taken transfers
      step({6'd3, 26'h000_0800}, 0, 0, 1, 0, "R9");
      step(br(6'd4, 16'd8), 4, 4, 1, 0, "R9");
      step(br(6'd4, 16'd8), 4, 4, 0, 0, "R3");
      // mixed stream
      for (int i = 0; i < 400; i++) begin
         logic [31:0] w, a, b;
         int k;
         k = $urandom_range(0, 6);
         a = $urandom;
         b = ($urandom_range(0, 1) == 1) ? a : $urandom;
         case (k)
            0: w = NOP;
            1: w = br(6'd4, 16'($urandom));
            2: w = br(6'd5, 16'($urandom));
            3: w = {6'd2, 26'($urandom)};
            4: w = {6'd3, 26'($urandom)};
            5: begin w = JREG; a = {a[31:2], 2'b00}; end
            default: w = {6'($urandom_range(6, 63)), 26'($urandom)};
         endcase
         step(w, a, b, ($urandom_range(0, 4) == 0), ($urandom_range(0, 60) == 0), "");
      end
      @(negedge clk);
      check(pc === m_pc, "R10", "final pc", pc, m_pc);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule